// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit down-counting timer channel. It advances only on cycles where a clock enable pulses at the timer oscillator rate, which is nominally 1193182 Hz and is produced by dividing the system clock outside this block. An access interface, also outside the block, gives it three things: an operating mode through a command strobe, a reload value, and a strobe that marks the reload value as complete. The channel drives an output pin level and a one-cycle interrupt request, and it exposes its live count for read-back.

The channel has three run states: stopped, armed and counting. A complete reload arms the channel. The next oscillator tick copies the effective reload value into the counter and starts counting. While counting, each tick decrements the counter. The tick that finds the count at 1 is a terminal event: it reloads the counter, and the output and interrupt rules of the current mode then apply. There are four modes:

- terminal-count interrupt
- one-shot
- rate generator
- square wave

The gate input is treated as always enabled. All pins are plain control and status pins. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `interval_timer_channel`

## Requirements
- R1: After reset the output level is low, there is no interrupt, the live count reads 0, and the channel is stopped.
- R2: A reload strobe arms the channel. The count does not change while the channel is armed and no tick arrives. The next tick loads the effective reload value, which then reads back on `live_count`, and the channel starts counting. A reload value of 0 counts as 65536 and reads back as 0.
- R3: A counting channel decrements once per tick and holds its count on cycles without a tick. The tick that finds the count at 1 reloads the effective value. For an effective value P, terminal events therefore occur every P ticks.
- R4: In square-wave mode (mode code 3), the effective reload value has its least significant bit cleared. This applies to the first load and to every reload. A result of 0 (reload value 0 or 1) counts as 65536.
- R5: In terminal-count interrupt mode (code 0) and one-shot mode (code 1), a terminal event drives the output high and raises an interrupt only if the output was low. Later events leave the output high and raise nothing.
- R6: In rate-generator mode (code 2), every terminal event raises an interrupt and the output level stays low.
- R7: In square-wave mode, every terminal event toggles the output. An interrupt is raised only on the events where the output goes high.
- R8: In rate-generator mode, a reload strobe that arrives while the channel is counting does not restart the count. The new value is used from the next terminal event onward.
- R9: A mode command drives the output low, stops the channel and clears any pending interrupt. A stopped channel holds its count and raises no interrupt whatever ticks arrive.
- R10: An interrupt request is high for exactly one cycle per terminal event. It rises on the same clock edge at which the counter reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Oscillator-rate clock enable |
| cmd_wr | input | 1 | Mode command strobe |
| cmd_mode | input | 2 | Mode code: 0 terminal-count interrupt, 1 one-shot, 2 rate generator, 3 square wave |
| reload_val | input | 16 | Reload value, sampled on `reload_done` |
| reload_done | input | 1 | Reload value complete strobe |
| out_level | output | 1 | Output pin level |
| irq_pulse | output | 1 | One-cycle interrupt request |
| live_count | output | 16 | Current count for read-back |

## Verification
Every mode is swept over reload values 1 to 7 and over 0. After each tick, the count, output and interrupt are compared with values worked out from the tick index modulo the effective period. Idle cycles are inserted between some ticks, which separates counting per tick from counting per clock. Odd reload values expose a missing or misplaced even-forcing in square-wave mode. Two directed sequences cover the remaining behaviour. In one, a rate-generator reload lands mid-count, and the next read shows whether the count continued or was reloaded. In the other, a mode command lands after the output has gone high, and the following ticks show whether the channel really stopped with its output low.

// File: rtl/itc_pkg.sv
package itc_pkg;
  typedef enum logic [1:0] {
    MODE_TC      = 2'd0,
    MODE_ONESHOT = 2'd1,
    MODE_RATE    = 2'd2,
    MODE_SQUARE  = 2'd3
  } itc_mode_e;

  typedef enum logic [1:0] {
    RUN_STOP  = 2'd0,
    RUN_ARMED = 2'd1,
    RUN_COUNT = 2'd2
  } itc_run_e;
endpackage

// File: rtl/itc_reload_fmt.sv
module itc_reload_fmt #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] raw_val,
  input  logic             square,
  output logic [CNT_W:0]   eff_val
);
  logic [CNT_W-1:0] shaped;

  always_comb begin
    shaped = square ? {raw_val[CNT_W-1:1], 1'b0} : raw_val;
    if (shaped == '0) eff_val = {1'b1, {CNT_W{1'b0}}};
    else              eff_val = {1'b0, shaped};
  end
endmodule

// File: rtl/itc_ctrl.sv
module itc_ctrl
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cfg_wr,
  input  itc_mode_e        cfg_mode,
  input  logic             load_done,
  input  logic [CNT_W-1:0] reload_in,
  output itc_mode_e        mode_q,
  output itc_run_e         run_q,
  output logic [CNT_W-1:0] reload_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_TC;
      run_q    <= RUN_STOP;
      reload_q <= '0;
    end else begin
      if (cfg_wr) begin
        mode_q <= cfg_mode;
        run_q  <= load_done ? RUN_ARMED : RUN_STOP;
      end else if (load_done) begin
        if (!(mode_q == MODE_RATE && run_q == RUN_COUNT)) run_q <= RUN_ARMED;
      end else if (run_q == RUN_ARMED && tick) begin
        run_q <= RUN_COUNT;
      end
      if (load_done) reload_q <= reload_in;
    end
  end

  p_rate_keeps_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q == RUN_COUNT && mode_q == MODE_RATE && load_done && !cfg_wr) |=> run_q == RUN_COUNT);
  p_cmd_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !load_done) |=> run_q == RUN_STOP);
endmodule

// File: rtl/itc_counter.sv
module itc_counter
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  itc_run_e       run_st,
  input  logic           square,
  input  logic [CNT_W:0] eff_reload,
  output logic [CNT_W:0] cnt,
  output logic           term
);
  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  assign term = tick && (run_st == RUN_COUNT) && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (tick) begin
      if (run_st == RUN_ARMED)      cnt <= eff_reload;
      else if (run_st == RUN_COUNT) cnt <= (cnt == ONE) ? eff_reload : cnt - ONE;
    end
  end

  p_stopped_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st == RUN_STOP) |=> $stable(cnt));
  p_even_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_st == RUN_ARMED && square) |=> !cnt[0]);
  p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_st == RUN_COUNT) |-> cnt != '0);
  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/itc_output.sv
module itc_output
  import itc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_wr,
  input  itc_mode_e mode,
  input  logic      term,
  output logic      out_q,
  output logic      irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_wr) begin
        out_q <= 1'b0;
      end else if (term) begin
        unique case (mode)
          MODE_TC, MODE_ONESHOT: begin
            if (!out_q) begin
              out_q <= 1'b1;
              irq_q <= 1'b1;
            end
          end
          MODE_RATE:   irq_q <= 1'b1;
          MODE_SQUARE: begin
            out_q <= ~out_q;
            irq_q <= ~out_q;
          end
        endcase
      end
    end
  end

  p_irq_from_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(term));
  p_level_irq_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && (mode == MODE_TC || mode == MODE_ONESHOT)) |-> $rose(out_q));
  p_square_irq_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && mode == MODE_SQUARE) |-> out_q);
  p_rate_out_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RATE) |-> !out_q);
endmodule

// File: rtl/interval_timer_channel.sv
module interval_timer_channel
  import itc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cmd_wr,
  input  logic [1:0]       cmd_mode,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             reload_done,
  output logic             out_level,
  output logic             irq_pulse,
  output logic [CNT_W-1:0] live_count
);
  itc_mode_e        mode_q;
  itc_run_e         run_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W:0]   eff_reload;
  logic [CNT_W:0]   cnt;
  logic             term;
  logic             square;

  assign square = (mode_q == MODE_SQUARE);

  itc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .cfg_wr(cmd_wr),
    .cfg_mode(itc_mode_e'(cmd_mode)), .load_done(reload_done), .reload_in(reload_val),
    .mode_q(mode_q), .run_q(run_q), .reload_q(reload_q)
  );

  itc_reload_fmt #(.CNT_W(CNT_W)) u_fmt (
    .raw_val(reload_q), .square(square), .eff_val(eff_reload)
  );

  itc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .run_st(run_q), .square(square),
    .eff_reload(eff_reload), .cnt(cnt), .term(term)
  );

  itc_output u_out (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cmd_wr), .mode(mode_q), .term(term),
    .out_q(out_level), .irq_q(irq_pulse)
  );

  assign live_count = cnt[CNT_W-1:0];

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_level && !irq_pulse && live_count == '0));
endmodule

// File: tb/sim_interval_timer_channel.sv
module sim_interval_timer_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [1:0]  cmd_mode = 2'd0;
  logic [15:0] reload_val = 16'd0;
  logic        reload_done = 1'b0;
  logic        out_level;
  logic        irq_pulse;
  logic [15:0] live_count;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_timer_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cmd_wr(cmd_wr), .cmd_mode(cmd_mode),
    .reload_val(reload_val), .reload_done(reload_done),
    .out_level(out_level), .irq_pulse(irq_pulse), .live_count(live_count)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int eff_period(input int m, input int n);
    int p;
    p = (m == 3) ? (n & 16'hFFFE) : n;
    return (p == 0) ? 65536 : p;
  endfunction

  task automatic set_mode(input int m);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_mode = 2'(m); tick_en = 1'b0; reload_done = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R9 mode cmd out", int'(out_level), 0);
    chk("R9 mode cmd irq", int'(irq_pulse), 0);
  endtask

  task automatic load(input int n);
    reload_done = 1'b1; reload_val = 16'(n);
    @(negedge clk);
    reload_done = 1'b0;
  endtask

  task automatic one_tick();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic run_case(input int m, input int n);
    int p, nt;
    p = eff_period(m, n);
    nt = (p <= 8) ? 3 * p + 1 : 3;
    set_mode(m);
    load(n);
    one_tick();
    chk((m == 3) ? "R4 first load" : "R2 first load", int'(live_count), p % 65536);
    chk("R2 no irq on load", int'(irq_pulse), 0);
    for (int j = 1; j <= nt; j++) begin
      int c, e, eo, ei;
      bit ev;
      one_tick();
      c = p - (j % p);
      ev = (j % p) == 0;
      e = j / p;
      case (m)
        0, 1: begin eo = (j >= p) ? 1 : 0; ei = (j == p) ? 1 : 0; end
        2:    begin eo = 0; ei = ev ? 1 : 0; end
        default: begin eo = e % 2; ei = (ev && (e % 2 == 1)) ? 1 : 0; end
      endcase
      chk((m == 3) ? "R4 count" : "R3 count", int'(live_count), c % 65536);
      if (m <= 1)      chk("R5 out", int'(out_level), eo);
      else if (m == 2) chk("R6 out", int'(out_level), eo);
      else             chk("R7 out", int'(out_level), eo);
      if (m <= 1)      chk("R5 irq", int'(irq_pulse), ei);
      else if (m == 2) chk("R6 irq", int'(irq_pulse), ei);
      else             chk("R7 irq", int'(irq_pulse), ei);
      if (j % 3 == 1) begin
        @(negedge clk);
        chk("R3 hold without tick", int'(live_count), c % 65536);
        chk("R10 irq one cycle", int'(irq_pulse), 0);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset out", int'(out_level), 0);
    chk("R1 reset irq", int'(irq_pulse), 0);
    chk("R1 reset count", int'(live_count), 0);
    one_tick();
    chk("R1 stopped after reset", int'(live_count), 0);

    // R2: armed channel holds until a tick arrives
    load(9);
    @(negedge clk);
    chk("R2 armed holds", int'(live_count), 0);
    one_tick();
    chk("R2 load on tick", int'(live_count), 9);

    for (int m = 0; m < 4; m++)
      for (int n = 0; n < 8; n++)
        run_case(m, n);

    // R8: rate generator reload mid-count does not restart
    set_mode(2);
    load(5);
    one_tick();
    one_tick();
    one_tick();
    chk("R8 before reload", int'(live_count), 3);
    load(3);
    one_tick();
    chk("R8 no restart", int'(live_count), 2);
    one_tick();
    chk("R8 continue", int'(live_count), 1);
    one_tick();
    chk("R8 new value at terminal", int'(live_count), 3);
    chk("R8 irq at terminal", int'(irq_pulse), 1);
    one_tick(); one_tick(); one_tick();
    chk("R8 period uses new value", int'(live_count), 3);
    chk("R8 irq second terminal", int'(irq_pulse), 1);

    // R9: mode command after output high stops the channel
    set_mode(0);
    load(2);
    one_tick();
    one_tick();
    one_tick();
    chk("R9 setup out high", int'(out_level), 1);
    chk("R9 setup count", int'(live_count), 2);
    set_mode(1);
    for (int k = 0; k < 3; k++) begin
      one_tick();
      chk("R9 stopped count", int'(live_count), 2);
      chk("R9 stopped out", int'(out_level), 0);
      chk("R9 stopped irq", int'(irq_pulse), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule